// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control words that fills a 4 KB byte-addressed window. A host reaches it through a plain single-cycle bus: a byte address, a write strobe, write data and read data. Each word is picked by the byte address divided by four, so the two lowest address bits do not matter. Writes land on the next rising clock edge. Reads are combinational and return the word the address selects in the same cycle.

Three parts give the bank more than plain storage. First, a command word at byte offset 0xF00 turns certain written values into one-cycle request pulses: values 1 and 2 raise a system reset request, and value 3 raises a shutdown request. Second, three status words at byte offsets 0x100, 0x108 and 0x10C always read back with bits 29 and 28 set, although the stored value is not changed. Third, the four words at word indices 0x40 to 0x43 come out of reset holding fixed identification values. Every other word resets to zero. The block only raises the request outputs; acting on them is left to logic outside the bank.

Top module: `sysctl_regbank`

## Requirements
- R1: A write stores `wr_data` in the word at index `addr[11:2]`. From the following cycle, a read of that word returns the value, unless it is one of the status words of R8.
- R2: After reset, word indices 0x40, 0x41, 0x42 and 0x43 hold 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121.
- R3: After reset, every other word of the 1024-word window holds zero.
- R4: A write of value 1 or value 2 to byte offset 0xF00 drives `sys_reset_req` high for exactly the one cycle after the write edge. `sys_shutdown_req` stays low.
- R5: A write of value 3 to byte offset 0xF00 drives `sys_shutdown_req` high for exactly the one cycle after the write edge. `sys_reset_req` stays low.
- R6: A write of any other value to offset 0xF00, or a write of any value to any other offset, raises neither request.
- R7: The command word at 0xF00 is real storage: the last value written to it reads back unchanged, whether or not it raised a request.
- R8: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. Reads at every other offset, including 0x104, return the stored word unmodified.
- R9: `rd_data` follows `addr` in the same cycle. A read and a write to the same word in one cycle return the old value.
- R10: Reset is synchronous and active-high. Both request outputs are low in the cycle after a reset edge, even when a qualifying command write is presented in that same cycle.
- R11: Address bits 1:0 are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address inside the 4 KB window |
| wr_en | input | 1 | Write strobe; the write happens at the next rising edge |
| wr_data | input | 32 | Data to store |
| rd_data | output | 32 | Combinational read data for `addr` |
| sys_reset_req | output | 1 | One-cycle system reset request pulse |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request pulse |

## Verification
The hardest case to reach is a command write that coincides with a reset edge. A qualifying value at offset 0xF00 must then produce no pulse, and the identification words must come back. The bench sets up exactly that cycle: it holds the strobe with value 1 at 0xF00 and raises reset in the same cycle. It then samples both request outputs and the restored words. The same-cycle read-during-write case is reached by sampling `rd_data` after the write is presented but before the edge. The pulse width is confirmed by sampling both the cycle after each command write and the cycle after that.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned ADDR_W  = 12;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned IDX_W   = ADDR_W - 2;
   localparam int unsigned N_WORDS = 1 << IDX_W;

   localparam logic [ADDR_W-1:0] CMD_BYTE_OFS = 12'hF00;

   localparam logic [DATA_W-1:0] CODE_RST_A = 32'd1;
   localparam logic [DATA_W-1:0] CODE_RST_B = 32'd2;
   localparam logic [DATA_W-1:0] CODE_OFF   = 32'd3;

   localparam int unsigned N_STATUS = 3;
   localparam logic [ADDR_W-1:0] STATUS_BYTE_OFS [N_STATUS] = '{12'h100, 12'h108, 12'h10C};
   localparam logic [DATA_W-1:0] STATUS_FORCE = 32'h3000_0000;

   typedef logic [IDX_W-1:0]  word_idx_t;
   typedef logic [DATA_W-1:0] word_t;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_RESET = 2'd1,
      CMD_HALT  = 2'd2
   } cmd_kind_t;

   function automatic word_t reset_word(input int unsigned idx);
      case (idx)
         32'h40:  return 32'h05F2_0121;
         32'h41:  return 32'h0000_0002;
         32'h42:  return 32'h05F3_0121;
         32'h43:  return 32'h05F4_0121;
         default: return '0;
      endcase
   endfunction

   function automatic cmd_kind_t classify_cmd(input word_t value);
      if (value == CODE_RST_A || value == CODE_RST_B) return CMD_RESET;
      else if (value == CODE_OFF)                     return CMD_HALT;
      else                                            return CMD_NONE;
   endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int unsigned WORDS = N_WORDS,
   parameter int unsigned WIDTH = DATA_W,
   localparam int unsigned IW   = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IW-1:0]    widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IW-1:0]    ridx,
   output logic [WIDTH-1:0] rdata
);

   initial begin
      assert (WORDS >= 2 && (1 << IW) == WORDS)
         else $fatal(1, "sysctl_store: WORDS must be a power of two");
      assert (WIDTH >= 1)
         else $fatal(1, "sysctl_store: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < WORDS; i++) begin
            mem[i] <= WIDTH'(reset_word(i));
         end
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];

   // R1: a stored word holds the written value one cycle later
   a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(widx)] == $past(wdata)));

   // R2: identification word holds its reset value after reset
   a_r2_id_word: assert property (@(posedge clk)
      rst |=> (mem[IW'(32'h40)] == WIDTH'(32'h05F2_0121)));

endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned AW = ADDR_W,
   parameter logic [AW-1:0] CMD_OFS = CMD_BYTE_OFS
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [AW-1:0] addr,
   input  word_t       wr_data,
   output logic        reset_req,
   output logic        halt_req
);

   initial begin
      assert (CMD_OFS[1:0] == 2'b00)
         else $fatal(1, "sysctl_cmd_decode: command offset must be word aligned");
   end

   logic      cmd_hit;
   cmd_kind_t kind;

   assign cmd_hit = wr_en && (addr[AW-1:2] == CMD_OFS[AW-1:2]);
   assign kind    = cmd_hit ? classify_cmd(wr_data) : CMD_NONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         reset_req <= 1'b0;
         halt_req  <= 1'b0;
      end else begin
         reset_req <= (kind == CMD_RESET);
         halt_req  <= (kind == CMD_HALT);
      end
   end

   // R4: reset code at command offset gives a reset request next cycle
   a_r4_reset_pulse: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr[AW-1:2] == CMD_OFS[AW-1:2] && (wr_data == 32'd1 || wr_data == 32'd2))
      |=> (reset_req && !halt_req));

   // R5: shutdown code gives a shutdown request next cycle
   a_r5_halt_pulse: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr[AW-1:2] == CMD_OFS[AW-1:2] && wr_data == 32'd3)
      |=> (halt_req && !reset_req));

   // R6: without a write strobe no request follows
   a_r6_no_write_no_req: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (!reset_req && !halt_req));

   // R10: requests are low after a reset edge
   a_r10_quiet_after_reset: assert property (@(posedge clk)
      rst |=> (!reset_req && !halt_req));

endmodule

// File: rtl/sysctl_rd_overlay.sv
module sysctl_rd_overlay
   import sysctl_pkg::*;
#(
   parameter int unsigned AW       = ADDR_W,
   parameter int unsigned NS       = N_STATUS,
   parameter logic [AW-1:0] OFS [NS] = STATUS_BYTE_OFS,
   parameter word_t         FORCE  = STATUS_FORCE
) (
   input  logic [AW-1:0] addr,
   input  word_t         raw,
   output word_t         shown,
   output logic          is_status
);

   initial begin
      assert (NS >= 1) else $fatal(1, "sysctl_rd_overlay: need at least one status word");
   end

   logic [NS-1:0] hit;

   for (genvar s = 0; s < NS; s++) begin : g_match
      assign hit[s] = (addr[AW-1:2] == OFS[s][AW-1:2]);
   end

   assign is_status = |hit;
   assign shown     = is_status ? (raw | FORCE) : raw;

   // R8: at most one status entry decodes a given address
   always_comb begin
      a_r8_unique_hit: assert ($onehot0(hit));
   end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              sys_reset_req,
   output logic              sys_shutdown_req
);

   word_idx_t idx;
   word_t     raw_word;
   logic      status_sel;

   assign idx = addr[ADDR_W-1:2];

   sysctl_store #(.WORDS(N_WORDS), .WIDTH(DATA_W)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .widx  (idx),
      .wdata (wr_data),
      .ridx  (idx),
      .rdata (raw_word)
   );

   sysctl_cmd_decode #(.AW(ADDR_W), .CMD_OFS(CMD_BYTE_OFS)) u_cmd (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .reset_req (sys_reset_req),
      .halt_req  (sys_shutdown_req)
   );

   sysctl_rd_overlay #(
      .AW(ADDR_W), .NS(N_STATUS), .OFS(STATUS_BYTE_OFS), .FORCE(STATUS_FORCE)
   ) u_overlay (
      .addr      (addr),
      .raw       (raw_word),
      .shown     (rd_data),
      .is_status (status_sel)
   );

   // R8: status reads always show bits 29 and 28 set
   a_r8_status_bits: assert property (@(posedge clk) disable iff (rst)
      status_sel |-> (rd_data[29:28] == 2'b11));

   // R4 / R5: the two requests are never raised together
   a_r5_exclusive_req: assert property (@(posedge clk) disable iff (rst)
      !(sys_reset_req && sys_shutdown_req));

endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;

   logic        clk = 1'b0;
   logic        rst;
   logic [11:0] addr;
   logic        wr_en;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        sys_reset_req;
   logic        sys_shutdown_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sysctl_regbank dut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .sys_reset_req(sys_reset_req), .sys_shutdown_req(sys_shutdown_req)
   );

   // vector: addr(12) data(32) expected readback(32) reset pulse(1) shutdown pulse(1)
   localparam int NV = 11;
   localparam logic [77:0] VEC [NV] = '{
      {12'h000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0},   // R1
      {12'hF00, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},   // R4 R7
      {12'hF00, 32'h0000_0002, 32'h0000_0002, 1'b1, 1'b0},   // R4
      {12'hF00, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b1},   // R5
      {12'hF00, 32'h0000_0004, 32'h0000_0004, 1'b0, 1'b0},   // R6 R7
      {12'hF00, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},   // R6
      {12'h100, 32'h0000_0000, 32'h3000_0000, 1'b0, 1'b0},   // R8
      {12'h104, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},   // R8 non-status
      {12'h10C, 32'h0000_00A5, 32'h3000_00A5, 1'b0, 1'b0},   // R8
      {12'h200, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0},   // R6 other offset
      {12'hFFC, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0}    // R1 top word
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
      addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   // write at the next edge; sample the pulse cycle and the cycle after
   task automatic wr(input logic [11:0] a, input logic [31:0] d,
                     input logic er, input logic es, input string tag);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " reset pulse"},    {31'd0, sys_reset_req},    {31'd0, er});
      check({tag, " shutdown pulse"}, {31'd0, sys_shutdown_req}, {31'd0, es});
      @(negedge clk);
      check({tag, " pulse width"}, {30'd0, sys_reset_req, sys_shutdown_req}, 32'd0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 reset req low", {30'd0, sys_reset_req, sys_shutdown_req}, 32'd0);
      rst = 1'b0;

      // reset state
      rd(12'h100, "R2 R8 word 0x40", 32'h35F2_0121);
      rd(12'h104, "R2 word 0x41",    32'h0000_0002);
      rd(12'h108, "R2 R8 word 0x42", 32'h35F3_0121);
      rd(12'h10C, "R2 R8 word 0x43", 32'h35F4_0121);
      rd(12'h000, "R3 word 0",       32'h0);
      rd(12'hF00, "R3 command word", 32'h0);
      rd(12'hFFC, "R3 last word",    32'h0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][77:66], VEC[v][65:34], VEC[v][1], VEC[v][0], $sformatf("vec%0d", v));
         rd(VEC[v][77:66], $sformatf("vec%0d readback", v), VEC[v][33:2]);
      end

      // R9: same-cycle read during write returns old value
      @(negedge clk);
      addr = 12'h010; wr_data = 32'hCAFE_0001; wr_en = 1'b1;
      #1;
      check("R9 old value during write", rd_data, 32'h0);
      @(posedge clk);
      #1;
      check("R9 new value after edge", rd_data, 32'hCAFE_0001);
      @(negedge clk);
      wr_en = 1'b0;

      // R11: low address bits ignored
      wr(12'h023, 32'h0000_0011, 1'b0, 1'b0, "R11 write");
      rd(12'h020, "R11 aligned read", 32'h0000_0011);
      rd(12'h022, "R11 offset read",  32'h0000_0011);
      wr(12'hF01, 32'h0000_0003, 1'b0, 1'b1, "R11 command unaligned");

      // R8: status forcing does not alter storage seen through other bits
      wr(12'h108, 32'hC000_0000, 1'b0, 1'b0, "R8 write high");
      rd(12'h108, "R8 high bits kept", 32'hF000_0000);

      // R10: command write together with reset edge
      @(negedge clk);
      addr = 12'hF00; wr_data = 32'd1; wr_en = 1'b1; rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rst = 1'b0;
      check("R10 no pulse under reset", {30'd0, sys_reset_req, sys_shutdown_req}, 32'd0);
      rd(12'h100, "R2 restored 0x40", 32'h35F2_0121);
      rd(12'h000, "R3 cleared word 0", 32'h0);
      rd(12'hF00, "R3 R7 command cleared", 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule